// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block sends one stereo sample pair per frame over a three-wire serial link: a bit clock, a word select line that tells the receiver which channel is on the wire, and a data line. Each channel word is 18 bits wide and two's complement. A frame is 64 bit slots long and splits into a left half and a right half of 32 slots each. The left word and the right word in one frame always come from the same parallel sample pair. That pair is copied into a shadow register as the left half starts.

A static mode input selects the clocking. In master mode the block runs from the system clock and generates its own bit clock and word select. The system clock is taken as the master clock. In slave mode both link clocks arrive from outside and pass through synchronisers. In that mode the block restarts its slot count on every word-select transition. A static format input selects the framing. The left-justified framing places the MSB in the first slot of each half and uses word select high for the left channel. The I2S-compatible framing places the MSB one slot later and uses word select low for the left channel.

Top module: `audio_serial_tx`

## Requirements
- R1: While reset is asserted, `sdataOut` and `bclkOut` are 0.
- R2: In master mode, `bclkOut` has a period of 4 clocks and is high for 2 of them. `wsOut` changes every 128 clocks. `wsOut` changes only in a cycle where `bclkOut` falls.
- R3: Each half frame carries its channel's 18-bit word MSB first. The receiver reads it on rising bit-clock edges, and both words of one frame come from one parallel pair.
- R4: Left-justified format (`fmtI2s`=0): word select is 1 for the left half. The MSB occupies slot 0 of each half and the LSB occupies slot 17.
- R5: I2S-compatible format (`fmtI2s`=1): word select is 0 for the left half. The MSB occupies slot 1 of each half and the LSB occupies slot 18.
- R6: Every slot of a half that does not carry a word bit drives 0.
- R7: In master mode, `sdataOut` changes only in a cycle where `bclkOut` falls.
- R8: The pair on `leftIn`/`rightIn` is captured as the left half begins. A change to these inputs during a frame first appears in the next frame.
- R9: Slave mode (`masterMode`=0): `bclkOut` and `wsOut` stay 0. `sdataOut` moves to the next slot's bit within SYNC_STAGES+1 clocks of each falling `bclkIn` edge. This timing is valid when each bit-clock phase lasts at least 4 clocks.
- R10: In slave mode, a word-select transition seen at a falling bit-clock edge restarts the count at slot 0 of the half that the new level marks. This happens no matter how many bit clocks preceded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (master clock) |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 = generate link clocks, 0 = accept them; static |
| fmtI2s | input | 1 | 1 = I2S-compatible framing, 0 = left-justified; static |
| leftIn | input | 18 | Left sample, two's complement |
| rightIn | input | 18 | Right sample, two's complement |
| bclkIn | input | 1 | Bit clock in slave mode |
| wsIn | input | 1 | Word select in slave mode |
| bclkOut | output | 1 | Bit clock in master mode, 0 in slave mode |
| wsOut | output | 1 | Word select in master mode, 0 in slave mode |
| sdataOut | output | 1 | Serial data, changes after falling bit-clock edges |

## Verification
A corrupted slot counter or divider moves the word within its half. The effect shows in the next frame as words shifted by whole bits, non-zero padding slots, or a missing MSB. Each of these is visible within 64 bit clocks.

A shadow register that loads at the wrong time mixes two sample pairs in one frame. That mix is exposed as soon as the parallel inputs change mid-frame.

In slave mode, a synchroniser or edge detector with the wrong latency makes the data change after the receiver samples. The error appears on the first word read after reset. A resynchronisation fault stays hidden until a frame arrives after an irregular number of bit clocks. The bench therefore sends frames with long preambles.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  // Slots per half frame, and the width of a whole-frame slot index.
  localparam int HALF_SLOTS = 32;
  localparam int SLOT_W     = $clog2(2 * HALF_SLOTS);

  // Strobes that the control sends to the datapath.
  typedef struct packed {
    logic              advance;   // a new slot begins at this clock edge
    logic              loadPair;  // the new slot is slot 0 of the left half
    logic [SLOT_W-1:0] slotNext;  // index of the slot that begins
  } txStrobe_t;
endpackage

// File: rtl/audio_tx_sync.sv
module audio_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int BCLK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterMode,
  input  logic      fmtI2s,
  input  logic      bclkIn,
  input  logic      wsIn,
  output logic      bclkOut,
  output logic      wsOut,
  output txStrobe_t strb
);
  localparam int PHASE_W = $clog2(BCLK_DIV);
  localparam int DIV_W   = PHASE_W + SLOT_W;

  // Master timing: the low bits count clocks within one bit, the high bits count slots.
  logic [DIV_W-1:0]  divCnt;
  logic              mBclk, mPhaseEnd, mLeftHalf;
  logic [SLOT_W-1:0] mSlot, mSlotNext;

  always_ff @(posedge clk) begin
    if (!rstN)           divCnt <= '0;
    else if (masterMode) divCnt <= divCnt + DIV_W'(1);
    else                 divCnt <= '0;
  end

  assign mBclk     = divCnt[PHASE_W-1];
  assign mPhaseEnd = &divCnt[PHASE_W-1:0];
  assign mSlot     = divCnt[DIV_W-1:PHASE_W];
  assign mSlotNext = mSlot + SLOT_W'(1);
  assign mLeftHalf = ~divCnt[DIV_W-1];

  // Slave timing: bring both link clocks into the system clock domain.
  logic bSync, wSync, bPrev, wsLast, sFall, wsEdge, sLeft;
  logic [SLOT_W-1:0] sSlot, sSlotNext;

  audio_tx_sync #(.STAGES(SYNC_STAGES)) i_bclkSync (
    .clk(clk), .rstN(rstN), .d(bclkIn), .q(bSync)
  );
  audio_tx_sync #(.STAGES(SYNC_STAGES)) i_wsSync (
    .clk(clk), .rstN(rstN), .d(wsIn), .q(wSync)
  );

  assign sFall  = bPrev & ~bSync;
  assign wsEdge = wSync ^ wsLast;
  assign sLeft  = fmtI2s ? ~wSync : wSync;

  always_comb begin
    if (wsEdge) sSlotNext = sLeft ? '0 : SLOT_W'(HALF_SLOTS);
    else        sSlotNext = sSlot + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrev  <= 1'b0;
      wsLast <= 1'b0;
      sSlot  <= '0;
    end else begin
      bPrev <= bSync;
      if (sFall) begin
        wsLast <= wSync;
        sSlot  <= sSlotNext;
      end
    end
  end

  // Strobes to the datapath, chosen by clocking mode.
  always_comb begin
    strb.advance  = masterMode ? mPhaseEnd : sFall;
    strb.slotNext = masterMode ? mSlotNext : sSlotNext;
    strb.loadPair = strb.advance && (strb.slotNext == '0);
  end

  assign bclkOut = masterMode & mBclk;
  assign wsOut   = masterMode & (fmtI2s ? ~mLeftHalf : mLeftHalf);
endmodule

// File: rtl/audio_tx_dp.sv
module audio_tx_dp
  import audio_tx_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fmtI2s,
  input  txStrobe_t         strb,
  input  logic [WORD_W-1:0] leftIn,
  input  logic [WORD_W-1:0] rightIn,
  output logic              sdataOut
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] shadowL, shadowR, srcL, srcR, wordSel;
  logic [IDX_W-1:0]  bitSel;
  logic              nextBit;
  int                pos, idx;

  // On the left-half boundary the MSB comes straight from the input being captured.
  assign srcL = strb.loadPair ? leftIn  : shadowL;
  assign srcR = strb.loadPair ? rightIn : shadowR;

  always_comb begin
    wordSel = strb.slotNext[SLOT_W-1] ? srcR : srcL;
    pos     = int'(strb.slotNext[SLOT_W-2:0]);
    idx     = pos - (fmtI2s ? 1 : 0);
    nextBit = 1'b0;
    bitSel  = '0;
    if (idx >= 0 && idx < WORD_W) begin
      bitSel  = IDX_W'(WORD_W - 1 - idx);
      nextBit = wordSel[bitSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowL  <= '0;
      shadowR  <= '0;
      sdataOut <= 1'b0;
    end else begin
      if (strb.loadPair) begin
        shadowL <= leftIn;
        shadowR <= rightIn;
      end
      if (strb.advance) sdataOut <= nextBit;
    end
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int BCLK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              fmtI2s,
  input  logic [WORD_W-1:0] leftIn,
  input  logic [WORD_W-1:0] rightIn,
  input  logic              bclkIn,
  input  logic              wsIn,
  output logic              bclkOut,
  output logic              wsOut,
  output logic              sdataOut
);
  txStrobe_t strb;

  audio_tx_ctrl #(.BCLK_DIV(BCLK_DIV), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .fmtI2s(fmtI2s),
    .bclkIn(bclkIn), .wsIn(wsIn), .bclkOut(bclkOut), .wsOut(wsOut), .strb(strb)
  );

  audio_tx_dp #(.WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .fmtI2s(fmtI2s), .strb(strb),
    .leftIn(leftIn), .rightIn(rightIn), .sdataOut(sdataOut)
  );
endmodule

// File: rtl/audio_tx_chk.sv
module audio_tx_chk (
  input logic clk,
  input logic rstN,
  input logic masterMode,
  input logic bclkOut,
  input logic wsOut,
  input logic sdataOut
);
  // R7
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !$stable(sdataOut)) |-> $fell(bclkOut));

  // R2
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !$stable(wsOut)) |-> $fell(bclkOut));

  // R2
  bclk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $rose(bclkOut)) |=> bclkOut);

  // R2
  bclk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $fell(bclkOut)) |=> !bclkOut);

  // R9
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!bclkOut && !wsOut));
endmodule

bind audio_serial_tx audio_tx_chk i_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .bclkOut(bclkOut), .wsOut(wsOut), .sdataOut(sdataOut)
);

// File: tb/test_audio_serial_tx.sv
module test_audio_serial_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterMode = 1'b1;
  logic        fmtI2s = 1'b0;
  logic [17:0] leftIn = '0;
  logic [17:0] rightIn = '0;
  logic        bclkIn = 1'b1;
  logic        wsIn = 1'b0;
  logic        bclkOut, wsOut, sdataOut;

  int testsRun = 0;
  int testsFailed = 0;
  logic [63:0] capBit, capWs;

  always #5 clk = ~clk;

  audio_serial_tx i_audio_serial_tx (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .fmtI2s(fmtI2s),
    .leftIn(leftIn), .rightIn(rightIn), .bclkIn(bclkIn), .wsIn(wsIn),
    .bclkOut(bclkOut), .wsOut(wsOut), .sdataOut(sdataOut)
  );

  // {master, i2s, preamble bits (slave), left, right}
  localparam logic [45:0] VECS [7] = '{
    {1'b1, 1'b0, 8'd0,  18'h2A5C3, 18'h15A3C},
    {1'b1, 1'b0, 8'd0,  18'h3FFFF, 18'h00001},
    {1'b1, 1'b1, 8'd0,  18'h20000, 18'h1FFFF},
    {1'b1, 1'b1, 8'd0,  18'h0F0F0, 18'h30F0F},
    {1'b0, 1'b0, 8'd5,  18'h12345, 18'h26789},
    {1'b0, 1'b1, 8'd45, 18'h38001, 18'h07FFE},
    {1'b0, 1'b0, 8'd45, 18'h2AAAA, 18'h15555}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyReset(input logic m, input logic f);
    @(negedge clk);
    rstN = 1'b0; masterMode = m; fmtI2s = f;
    bclkIn = 1'b1; wsIn = f;  // right-half level of the chosen format
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Receiver for master mode: collects 64 slots from a left-half start.
  task automatic captureMaster(input int chgAt, input logic [17:0] nl, input logic [17:0] nr);
    logic leftLvl, prevB, lastWs, started;
    int got;
    leftLvl = ~fmtI2s; prevB = bclkOut; lastWs = leftLvl; started = 1'b0; got = 0;
    while (got < 64) begin
      @(negedge clk);
      if (bclkOut && !prevB) begin
        if (!started && wsOut == leftLvl && lastWs != leftLvl) started = 1'b1;
        if (started) begin
          capBit[got] = sdataOut;
          capWs[got]  = wsOut;
          if (got == chgAt) begin leftIn = nl; rightIn = nr; end
          got++;
        end
        lastWs = wsOut;
      end
      prevB = bclkOut;
    end
  endtask

  // One bit-clock period in slave mode: 8 system clocks.
  task automatic sendBit(input logic ws, output logic b);
    @(negedge clk);
    bclkIn = 1'b0; wsIn = ws;
    repeat (4) @(negedge clk);
    b = sdataOut;
    bclkIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic slaveFrame(input int pre);
    logic leftLvl, junk;
    leftLvl = ~fmtI2s;
    for (int k = 0; k < pre; k++) sendBit(~leftLvl, junk);
    for (int k = 0; k < 64; k++) begin
      capWs[k] = (k < 32) ? leftLvl : ~leftLvl;
      sendBit(capWs[k], capBit[k]);
    end
  endtask

  task automatic checkFrame(input logic [17:0] expL, input logic [17:0] expR,
                            input logic chkWs, input string tag);
    logic [17:0] gotL, gotR;
    logic padBad, wsBad, leftLvl;
    int off;
    off = fmtI2s ? 1 : 0;
    leftLvl = ~fmtI2s;
    padBad = 1'b0; wsBad = 1'b0;
    for (int k = 0; k < 18; k++) begin
      gotL[17-k] = capBit[off+k];
      gotR[17-k] = capBit[32+off+k];
    end
    for (int k = 0; k < 64; k++) begin
      if (((k % 32) < off || (k % 32) >= off + 18) && capBit[k]) padBad = 1'b1;
      if (capWs[k] != ((k < 32) ? leftLvl : ~leftLvl)) wsBad = 1'b1;
    end
    check(gotL == expL, {tag, " R3 left word"}, 32'(gotL), 32'(expL));
    check(gotR == expR, {tag, " R3 right word"}, 32'(gotR), 32'(expR));
    check(!padBad, "R6 padding slots zero", 32'(padBad), 32'd0);
    if (chkWs) check(!wsBad, {tag, " word select level per half"}, 32'(wsBad), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    logic [45:0] v;
    string tag;
    int t0, t1;
    logic pb, pw;

    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    check(sdataOut == 1'b0, "R1 sdataOut in reset", 32'(sdataOut), 32'd0);
    check(bclkOut == 1'b0, "R1 bclkOut in reset", 32'(bclkOut), 32'd0);

    // Table walk: R4/R5 per format, R9 for slave rows, R10 for long preambles
    for (int i = 0; i < 7; i++) begin
      v = VECS[i];
      leftIn = v[35:18]; rightIn = v[17:0];
      applyReset(v[45], v[44]);
      if (v[44]) tag = "R5"; else tag = "R4";
      if (v[45]) begin
        captureMaster(-1, '0, '0);
        checkFrame(v[35:18], v[17:0], 1'b1, tag);
      end else begin
        slaveFrame(int'(v[43:36]));
        if (v[43:36] > 8'd32) tag = {tag, " R10 R9"}; else tag = {tag, " R9"};
        checkFrame(v[35:18], v[17:0], 1'b0, tag);
        check(!bclkOut && !wsOut, "R9 link clock outputs idle in slave",
              32'({bclkOut, wsOut}), 32'd0);
      end
    end

    // R2: master bit-clock period and word-select half period
    applyReset(1'b1, 1'b0);
    pb = bclkOut; t0 = -1; t1 = -1;
    for (int c = 0; c < 40 && t1 < 0; c++) begin
      @(negedge clk);
      if (bclkOut && !pb) begin if (t0 < 0) t0 = c; else t1 = c; end
      pb = bclkOut;
    end
    check(t1 - t0 == 4, "R2 bit clock period", 32'(t1 - t0), 32'd4);
    pw = wsOut; t0 = -1; t1 = -1;
    for (int c = 0; c < 600 && t1 < 0; c++) begin
      @(negedge clk);
      if (wsOut != pw) begin if (t0 < 0) t0 = c; else t1 = c; end
      pw = wsOut;
    end
    check(t1 - t0 == 128, "R2 word select half period", 32'(t1 - t0), 32'd128);

    // R8: mid-frame input change lands in the following frame only
    leftIn = 18'h0C0C3; rightIn = 18'h3C3C0;
    applyReset(1'b1, 1'b0);
    captureMaster(10, 18'h1E1E1, 18'h21212);
    checkFrame(18'h0C0C3, 18'h3C3C0, 1'b1, "R8 current frame");
    captureMaster(-1, '0, '0);
    checkFrame(18'h1E1E1, 18'h21212, 1'b1, "R8 next frame");

    // R8 in I2S framing, change in the right half
    leftIn = 18'h00FFF; rightIn = 18'h3F000;
    applyReset(1'b1, 1'b1);
    captureMaster(40, 18'h11111, 18'h22222);
    checkFrame(18'h00FFF, 18'h3F000, 1'b1, "R8 R5 current frame");
    captureMaster(-1, '0, '0);
    checkFrame(18'h11111, 18'h22222, 1'b1, "R8 R5 next frame");

    // R1: reset after activity returns outputs low
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(sdataOut == 1'b0 && bclkOut == 1'b0, "R1 outputs after re-reset",
          32'({sdataOut, bclkOut}), 32'd0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule